// File: doc/BRIEF.md
# Audio Transmit Sample Buffer with Underrun Replay

This block is a small first-in first-out store that holds outgoing audio samples for one channel. A DMA engine in the system clock domain writes 32-bit samples into it. A link serializer asks for one sample per frame by raising a frame tick that arrives asynchronously. The tick is synchronized into the system clock, and each rising edge pops one sample onto a held output register. While occupancy is under half, the block asks the DMA engine for more data. After reset, and again after the channel is re-enabled, it releases nothing until it has been filled to half capacity at least once.

When a frame request finds the buffer empty, the output register keeps the last sample it sent. The link therefore repeats that sample instead of sending silence, and a sticky underrun flag is set. The flag drives an interrupt line through an enable bit and is cleared by a write-one pulse. A build option makes the buffer a 16-bit channel: the upper half of every stored word is then forced to zero.

Top module: `audio_tx_sample_fifo`

## Requirements
- R1: The buffer holds DEPTH (default 16) entries of DATA_W (default 32) bits. A write made while all entries are occupied is dropped: it changes neither the occupancy nor any later output.
- R2: `dma_req` is high exactly when `enable` is high and fewer than REQ_LEVEL (default 8) entries are held. It follows the occupancy one clock after the write or pop that changes it.
- R3: After reset or re-enable, frame requests have no effect until the occupancy has reached START_LEVEL (default 8). Such requests leave `tx_sample` unchanged and do not set the underrun flag.
- R4: Once released, each frame request that finds data pops the oldest entry onto `tx_sample`. Samples come out in write order, and `tx_sample` is 0 after reset.
- R5: Once released, a frame request that finds the buffer empty leaves `tx_sample` at the last sample sent and sets `underrun_sts`.
- R6: `underrun_sts` stays set until a cycle in which `sts_clear` is high. If an underrun occurs in that same cycle, the flag stays set.
- R7: `irq` is high exactly when `underrun_sts` and `irq_en` are both high.
- R8: With HALF_WIDTH=1, bits DATA_W-1:16 of every sample presented on `tx_sample` are zero and bits 15:0 equal the written bits 15:0.
- R9: `frame_tick` is synchronized through SYNC_STAGES flops. Each rising edge produces exactly one request, however long the level stays high. The request acts on the third clock edge after the tick rises (default SYNC_STAGES=2).
- R10: While `enable` is low, the buffer is emptied, writes are dropped and the start gate is re-armed.
- R11: After an underrun, a sample written later replaces the replayed one at the next frame request, without waiting for the start level again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; low flushes and re-arms the start gate |
| wr_valid | input | 1 | Write strobe from the DMA side |
| wr_data | input | DATA_W | Sample to store |
| dma_req | output | 1 | Refill request while occupancy is below REQ_LEVEL |
| frame_tick | input | 1 | Asynchronous per-frame sample request from the link side |
| tx_sample | output | DATA_W | Sample currently presented to the link |
| sts_clear | input | 1 | Write-one pulse clearing the underrun flag |
| irq_en | input | 1 | Interrupt enable for the underrun flag |
| underrun_sts | output | 1 | Sticky underrun flag |
| irq | output | 1 | Underrun interrupt |

## Verification
The bench builds two copies side by side: the default 16-deep, 32-bit configuration, and the same configuration with HALF_WIDTH=1. Both copies receive identical stimulus. The small depth lets the bench sweep every occupancy from empty to full and back. It compares `dma_req` at each level against the threshold, and each popped sample against a value computed from its write index. That sweep reaches the full-buffer drop, the start gate below half, the empty-buffer replay, and the same-cycle clear and set of the status flag. The narrow copy shows that the upper half is masked on every sample of the sweep.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;

  // occupancy threshold test used for refill request and start gate
  function automatic bit level_below(int unsigned occ, int unsigned lvl);
    return occ < lvl;
  endfunction

  // circular pointer advance for any depth
  function automatic int unsigned ptr_advance(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/aud_tick_sync.sv
module aud_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_rise
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], tick_async};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign tick_rise = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/aud_fifo_store.sv
module aud_fifo_store
  import aud_fifo_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] occ
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= AW'(ptr_advance(32'(wr_ptr_q), DEPTH));
      if (pop)  rd_ptr_q <= AW'(ptr_advance(32'(rd_ptr_q), DEPTH));
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign rdata = mem[rd_ptr_q];
  assign occ   = occ_q;
endmodule

// File: rtl/audio_tx_sample_fifo.sv
module audio_tx_sample_fifo
  import aud_fifo_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 16,
  parameter int REQ_LEVEL   = DEPTH / 2,
  parameter int START_LEVEL = DEPTH / 2,
  parameter int SYNC_STAGES = 2,
  parameter bit HALF_WIDTH  = 1'b0,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dma_req,
  input  logic              frame_tick,
  output logic [DATA_W-1:0] tx_sample,
  input  logic              sts_clear,
  input  logic              irq_en,
  output logic              underrun_sts,
  output logic              irq
);
  // named internal events, observed by the bound checker
  logic              slot_req;
  logic              push_evt;
  logic              pop_evt;
  logic              underrun_evt;
  logic              started_q;
  logic [CW-1:0]     occ;
  logic [DATA_W-1:0] head;
  logic [DATA_W-1:0] wdata_m;
  logic [DATA_W-1:0] tx_q;
  logic              sts_q;

  generate
    if (HALF_WIDTH) begin : g_narrow
      assign wdata_m = {{(DATA_W-16){1'b0}}, wr_data[15:0]};
    end else begin : g_full
      assign wdata_m = wr_data;
    end
  endgenerate

  aud_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_async (frame_tick),
    .tick_rise  (slot_req)
  );

  assign push_evt     = enable & wr_valid & (occ != CW'(DEPTH));
  assign pop_evt      = enable & started_q & slot_req & (occ != '0);
  assign underrun_evt = enable & started_q & slot_req & (occ == '0);

  aud_fifo_store #(.W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (~enable),
    .push  (push_evt),
    .wdata (wdata_m),
    .pop   (pop_evt),
    .rdata (head),
    .occ   (occ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      tx_q      <= '0;
      sts_q     <= 1'b0;
    end else begin
      if (!enable)
        started_q <= 1'b0;
      else if (!level_below(32'(occ), START_LEVEL))
        started_q <= 1'b1;
      if (pop_evt)
        tx_q <= head;
      if (underrun_evt)
        sts_q <= 1'b1;
      else if (sts_clear)
        sts_q <= 1'b0;
    end
  end

  assign dma_req      = enable & level_below(32'(occ), REQ_LEVEL);
  assign tx_sample    = tx_q;
  assign underrun_sts = sts_q;
  assign irq          = sts_q & irq_en;
endmodule

// File: rtl/aud_fifo_checker.sv
module aud_fifo_checker #(
  parameter int DEPTH     = 16,
  parameter int REQ_LEVEL = 8,
  parameter int W         = 32,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          sts_clear,
  input logic          irq_en,
  input logic          dma_req,
  input logic [W-1:0]  tx_sample,
  input logic          underrun_sts,
  input logic          irq,
  input logic [CW-1:0] occ,
  input logic          started,
  input logic          pop_evt,
  input logic          underrun_evt
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && occ == CW'(DEPTH) && !pop_evt) |=> occ == CW'(DEPTH));

  assert_dma_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= CW'(REQ_LEVEL)) |-> !dma_req);

  assert_dma_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !dma_req);

  assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !started |=> $stable(tx_sample));

  assert_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> ($stable(tx_sample) && underrun_sts));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_sts && !sts_clear) |=> underrun_sts);

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && underrun_sts));
endmodule

bind audio_tx_sample_fifo aud_fifo_checker #(
  .DEPTH(DEPTH), .REQ_LEVEL(REQ_LEVEL), .W(DATA_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .sts_clear    (sts_clear),
  .irq_en       (irq_en),
  .dma_req      (dma_req),
  .tx_sample    (tx_sample),
  .underrun_sts (underrun_sts),
  .irq          (irq),
  .occ          (occ),
  .started      (started_q),
  .pop_evt      (pop_evt),
  .underrun_evt (underrun_evt)
);

// File: tb/test_audio_tx_sample_fifo.sv
module test_audio_tx_sample_fifo;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic frame_tick = 1'b0;
  logic sts_clear = 1'b0;
  logic irq_en = 1'b0;
  logic dma_req, underrun_sts, irq;
  logic dma_req_n, underrun_sts_n, irq_n;
  logic [W-1:0] tx_sample, tx_sample_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  audio_tx_sample_fifo i_audio_tx_sample_fifo (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_valid(wr_valid),
    .wr_data(wr_data), .dma_req(dma_req), .frame_tick(frame_tick),
    .tx_sample(tx_sample), .sts_clear(sts_clear), .irq_en(irq_en),
    .underrun_sts(underrun_sts), .irq(irq)
  );

  audio_tx_sample_fifo #(.HALF_WIDTH(1'b1)) i_audio_tx_sample_fifo_half (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_valid(wr_valid),
    .wr_data(wr_data), .dma_req(dma_req_n), .frame_tick(frame_tick),
    .tx_sample(tx_sample_n), .sts_clear(sts_clear), .irq_en(irq_en),
    .underrun_sts(underrun_sts_n), .irq(irq_n)
  );

  function automatic logic [W-1:0] smp(int i);
    return (32'hBEE0_0000 + (32'(i) << 16)) | (32'h1000 + 32'(i) * 7);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_tx(string req, logic [W-1:0] exp);
    chk(req, tx_sample, exp);
    chk({req, " R8"}, tx_sample_n, {16'h0, exp[15:0]});
  endtask

  task automatic put(logic [W-1:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  // one rising edge of the frame tick; request acts at the third edge
  task automatic tick(bit clr_same, int hold);
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk);
    @(negedge clk); if (clr_same) sts_clear = 1'b1;
    @(negedge clk); sts_clear = 1'b0;
    repeat (hold) @(negedge clk);
    frame_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 dma_req disabled", 32'(dma_req), 0);
    chk_tx("R4 reset sample", '0);
    chk("R6 reset status", 32'(underrun_sts), 0);
    chk("R7 reset irq", 32'(irq), 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R2 dma_req empty", 32'(dma_req), 1);

    for (int i = 0; i < 7; i++) begin
      put(smp(i));
      chk("R2 dma_req fill", 32'(dma_req), 1);
    end
    tick(1'b0, 0);
    chk_tx("R3 gate holds sample", '0);
    chk("R3 no underrun before start", 32'(underrun_sts), 0);
    for (int i = 7; i < 16; i++) begin
      put(smp(i));
      chk("R2 dma_req fill", 32'(dma_req), 0);
    end
    put(smp(99));

    for (int k = 0; k < 16; k++) begin
      tick(1'b0, 0);
      chk_tx("R4 pop order", smp(k));
      chk("R2 dma_req drain", 32'(dma_req), 32'((15 - k) < 8));
    end

    tick(1'b0, 0);
    chk_tx("R1 R5 replay last sample", smp(15));
    chk("R5 underrun set", 32'(underrun_sts), 1);
    chk("R7 irq masked", 32'(irq), 0);
    repeat (5) @(negedge clk);
    chk("R6 sticky", 32'(underrun_sts), 1);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R7 irq enabled", 32'(irq), 1);
    sts_clear = 1'b1; @(negedge clk); sts_clear = 1'b0;
    @(negedge clk);
    chk("R6 cleared", 32'(underrun_sts), 0);
    chk("R7 irq drops", 32'(irq), 0);

    put(smp(20));
    tick(1'b0, 0);
    chk_tx("R11 new data replaces replay", smp(20));
    tick(1'b1, 0);
    chk_tx("R5 replay again", smp(20));
    chk("R6 set wins over clear", 32'(underrun_sts), 1);
    sts_clear = 1'b1; @(negedge clk); sts_clear = 1'b0;

    put(smp(21));
    put(smp(22));
    enable = 1'b0;
    @(negedge clk);
    chk("R10 dma_req off while disabled", 32'(dma_req), 0);
    put(smp(23));
    enable = 1'b1;
    @(negedge clk);
    chk("R10 flushed refill request", 32'(dma_req), 1);
    for (int i = 30; i < 33; i++) put(smp(i));
    tick(1'b0, 0);
    chk_tx("R10 R3 gate re-armed", smp(20));
    chk("R3 no underrun while gated", 32'(underrun_sts), 0);
    for (int i = 33; i < 39; i++) put(smp(i));
    tick(1'b0, 0);
    chk_tx("R10 flush dropped old data", smp(30));

    tick(1'b0, 12);
    chk_tx("R9 held tick pops once", smp(31));
    tick(1'b0, 0);
    chk_tx("R9 next edge pops next", smp(32));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule